// File: doc/BRIEF.md
# ADC Conversion Sequencer with Host Registers

This block sits between a host bus and a multi-channel converter front end. The host programs a small bank of byte-wide registers: the front-end parameters, the averaging control, the channel, the settle delay and the enable. It then writes a start request. The sequencer drives the programmed channel to the analog multiplexer and waits a settle time. It then collects a power-of-two number of raw 16-bit samples from the front end, averages them and posts the 16-bit result.

The settle delay is taken from a 16-entry table indexed by a 4-bit register field. The contents of that table depend on the digital revision, which is fixed by parameters. The microsecond time base is derived from the clock frequency parameter. To detect completion, the host can poll the status register for the pattern "done set, pending clear". It can also wait for the one-cycle end-of-conversion interrupt.

Top module: `adc_conv_seq`

## Requirements
- R1: Register map, with reads returning the masked value. Offset 0x00 reads the minor revision and 0x01 the major revision. Offset 0x42 (front-end parameters) keeps bits 6:2 (mask 0x7C). Offset 0x43 (averaging) keeps bit 7 (enable) and bits 2:0 (log2 count), mask 0x87. Offset 0x44 (channel) keeps all 8 bits. Offset 0x45 (settle index) keeps bits 3:0. Offset 0x46 (enable) keeps bit 7. Offset 0x47 (start) always reads 0.
- R2: After reset, every writable register reads 0. Status word 1 (0x08) and status word 2 (0x09) read 0, and `eoc_irq` and `sample_en` are low.
- R3: A write of bit 7 = 1 to 0x47 while bit 7 of 0x46 is set and the sequencer is idle starts a conversion. On the edge after the write, 0x08 reads 0x02 (bit 1 pending = 1, bit 0 done = 0), 0x09 reads 0x10, and `mux_sel` equals the channel register. Bits 6:4 of 0x09 give the state: idle 0, settle 1, sample 2, average 3, done 4.
- R4: `sample_en` rises D*T+1 clock edges after the start edge. D is the table delay in microseconds and T = CLK_FREQ_HZ/1,000,000. For revision 5.3 and later, the table is: index 0 → 15 µs, indices 1–7 → 100·index µs, indices 8–15 → 1, 2, 4 … 128 ms.
- R5: For revisions below 5.3, indices 0–7 are the same as in R4. Index 8 → 800 µs, 9 → 900 µs, and 10–15 → 1, 2, 4, 6, 8, 10 ms.
- R6: Samples are accepted only while `sample_en` is high, which is also when 0x09 reads 0x20. A `smp_valid` at any other time has no effect on the result.
- R7: The number of samples is 2^k when bit 7 of 0x43 is set (k = bits 2:0) and 1 otherwise. The result is the sum shifted right by k, truncated toward zero. 0x50 holds the low byte and 0x51 the high byte.
- R8: Timing of completion:
  - On the edge after the last sample is taken, 0x09 reads 0x30.
  - On the following edge, 0x08 reads 0x01, 0x09 reads 0x40, the result is valid, and `eoc_irq` is high.
  - One edge later, `eoc_irq` is low and 0x09 reads 0x00.
- R9: A start request while 0x46 bit 7 is 0 is ignored. Pending stays 0, the done bit keeps its value, and the sequencer stays idle.
- R10: A start request during a conversion is ignored. The conversion continues with its original sample count.
- R11: All six registers 0x42–0x47 may be written on consecutive cycles, with the start request last. The conversion then uses the values written in that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset for reads and writes |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| mux_sel | output | 8 | Channel selection to the analog multiplexer |
| sample_en | output | 1 | High while the sequencer is collecting samples |
| smp_valid | input | 1 | Raw sample strobe from the front end |
| smp_data | input | 16 | Raw sample value |
| eoc_irq | output | 1 | One-cycle end-of-conversion pulse |

## Verification
The read path has no register, so status and result bytes are checked 1 ns after the edge that changes them. The start request changes the status on the first edge. `sample_en` is checked on the edge counted from the settle table and the time base, and no earlier. The averaging state shows on the edge after the last accepted sample, and the done status, result and interrupt appear one edge after that. The bench counts every edge from the start write. It also drives a stray sample strobe with all-ones data throughout the settle wait, so that an early acceptance corrupts the average it predicts.

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int CLK_FREQ_HZ = 19_200_000,
  parameter int REV_MAJOR   = 5,
  parameter int REV_MINOR   = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_we,
  input  logic [7:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [7:0]  mux_sel,
  output logic        sample_en,
  input  logic        smp_valid,
  input  logic [15:0] smp_data,
  output logic        eoc_irq
);
  localparam int TPU   = (CLK_FREQ_HZ / 1_000_000 < 1) ? 1 : CLK_FREQ_HZ / 1_000_000;
  localparam int PRE_W = (TPU > 1) ? $clog2(TPU) : 1;
  localparam bit NEW_TABLE = (REV_MAJOR > 5) || (REV_MAJOR == 5 && REV_MINOR >= 3);
  localparam int SUM_W = 24;

  typedef enum logic [2:0] {S_IDLE, S_SETTLE, S_SAMPLE, S_AVG, S_DONE} st_t;

  function automatic logic [16:0] settle_us(input logic [3:0] idx);
    if (idx < 4'd8)
      return (idx == 4'd0) ? 17'd15 : 17'(idx) * 17'd100;
    if (NEW_TABLE)
      return 17'd1000 << (idx - 4'd8);
    case (idx)
      4'd8:    return 17'd800;
      4'd9:    return 17'd900;
      4'd10:   return 17'd1000;
      4'd11:   return 17'd2000;
      4'd12:   return 17'd4000;
      4'd13:   return 17'd6000;
      4'd14:   return 17'd8000;
      default: return 17'd10000;
    endcase
  endfunction

  logic [7:0] dig_q, chan_q;
  logic       avg_en_q;
  logic [2:0] avg_lg_q;
  logic [3:0] dly_q;
  logic       en_q, pend_q, eoc_q;
  logic [15:0] res_q;
  st_t        st_q;
  logic [16:0] us_q;
  logic [PRE_W-1:0] pre_q;
  logic [7:0] cnt_q;
  logic [SUM_W-1:0] sum_q;

  wire       req_wr = bus_we && bus_addr == 8'h47 && bus_wdata[7];
  wire       start  = req_wr && en_q && st_q == S_IDLE;
  wire [2:0] lg     = avg_en_q ? avg_lg_q : 3'd0;
  wire [8:0] n_smp  = 9'd1 << lg;
  wire       take   = st_q == S_SAMPLE && smp_valid;

  assign mux_sel   = chan_q;
  assign sample_en = st_q == S_SAMPLE;
  assign eoc_irq   = st_q == S_DONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dig_q <= '0; chan_q <= '0; avg_en_q <= 1'b0; avg_lg_q <= '0;
      dly_q <= '0; en_q <= 1'b0;
    end else if (bus_we) begin
      case (bus_addr)
        8'h42: dig_q <= bus_wdata & 8'h7C;
        8'h43: begin avg_en_q <= bus_wdata[7]; avg_lg_q <= bus_wdata[2:0]; end
        8'h44: chan_q <= bus_wdata;
        8'h45: dly_q <= bus_wdata[3:0];
        8'h46: en_q <= bus_wdata[7];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; us_q <= '0; pre_q <= '0; cnt_q <= '0; sum_q <= '0;
      pend_q <= 1'b0; eoc_q <= 1'b0; res_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q <= S_SETTLE; us_q <= settle_us(dly_q); pre_q <= '0;
          pend_q <= 1'b1; eoc_q <= 1'b0;
        end
        S_SETTLE: begin
          if (us_q == '0) begin
            st_q <= S_SAMPLE; cnt_q <= '0; sum_q <= '0;
          end else if (pre_q == PRE_W'(TPU - 1)) begin
            pre_q <= '0; us_q <= us_q - 17'd1;
          end else begin
            pre_q <= pre_q + 1'b1;
          end
        end
        S_SAMPLE: if (take) begin
          sum_q <= sum_q + SUM_W'(smp_data);
          cnt_q <= cnt_q + 8'd1;
          if (9'(cnt_q) + 9'd1 == n_smp) st_q <= S_AVG;
        end
        S_AVG: begin
          res_q <= 16'(sum_q >> lg);
          eoc_q <= 1'b1; pend_q <= 1'b0; st_q <= S_DONE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      8'h00:   bus_rdata = 8'(REV_MINOR);
      8'h01:   bus_rdata = 8'(REV_MAJOR);
      8'h08:   bus_rdata = {6'd0, pend_q, eoc_q};
      8'h09:   bus_rdata = {1'b0, st_q, 4'd0};
      8'h42:   bus_rdata = dig_q;
      8'h43:   bus_rdata = {avg_en_q, 4'd0, avg_lg_q};
      8'h44:   bus_rdata = chan_q;
      8'h45:   bus_rdata = {4'd0, dly_q};
      8'h46:   bus_rdata = {en_q, 7'd0};
      8'h50:   bus_rdata = res_q[7:0];
      8'h51:   bus_rdata = res_q[15:8];
      default: bus_rdata = 8'd0;
    endcase
  end

  // R8
  pend_eoc_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(pend_q && eoc_q));
  // R8
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n) eoc_irq |-> (eoc_q && !pend_q));
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n) eoc_irq |=> !eoc_irq);
  // R6
  sample_pend_chk: assert property (@(posedge clk) disable iff (!rst_n) sample_en |-> pend_q);
  // R9
  req_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_wr && !en_q && st_q == S_IDLE) |=> !pend_q);
  // R4
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_SETTLE && us_q != '0) |=> st_q == S_SETTLE);
  // R3
  state_range_chk: assert property (@(posedge clk) disable iff (!rst_n) st_q <= S_DONE);
endmodule

// File: tb/adc_conv_seq_tb_top.sv
module adc_conv_seq_tb_top;
  localparam int FREQ = 2_000_000;
  localparam int TPU  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we_a = 1'b0, we_b = 1'b0;
  logic [7:0] addr = 8'd0, wdata = 8'd0;
  logic [7:0] rdata_a, rdata_b, mux_a, mux_b;
  logic sen_a, sen_b, irq_a, irq_b;
  logic svalid = 1'b0;
  logic [15:0] sdata = 16'd0;
  int tests = 0, fails = 0, cyc = 0;

  always #5 clk = ~clk;

  adc_conv_seq #(.CLK_FREQ_HZ(FREQ), .REV_MAJOR(5), .REV_MINOR(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we_a), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_a), .mux_sel(mux_a), .sample_en(sen_a), .smp_valid(svalid),
    .smp_data(sdata), .eoc_irq(irq_a));

  adc_conv_seq #(.CLK_FREQ_HZ(FREQ), .REV_MAJOR(5), .REV_MINOR(2)) dut_old_i (
    .clk(clk), .rst_n(rst_n), .bus_we(we_b), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata_b), .mux_sel(mux_b), .sample_en(sen_b), .smp_valid(svalid),
    .smp_data(sdata), .eoc_irq(irq_b));

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int settle_ref(input int idx, input bit newrev);
    int old_ms[6] = '{1, 2, 4, 6, 8, 10};
    if (idx == 0) return 15;
    if (idx < 8) return idx * 100;
    if (newrev) return 1000 << (idx - 8);
    if (idx == 8) return 800;
    if (idx == 9) return 900;
    return old_ms[idx - 10] * 1000;
  endfunction

  task automatic peek(input bit sel, input logic [7:0] a, output logic [7:0] v);
    addr = a; #1; v = sel ? rdata_b : rdata_a;
  endtask

  task automatic wr(input bit sel, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d;
    if (sel) we_b = 1'b1; else we_a = 1'b1;
    @(posedge clk); #1;
    we_a = 1'b0; we_b = 1'b0;
  endtask

  task automatic run_conv(input bit sel, input int idx, input logic [7:0] avgv,
                          input logic [7:0] chan, input bit ones, input bit busy_req);
    logic [7:0] v;
    int n, cnt, sum, lg, exp_res;
    bit seen;
    lg = avgv[7] ? int'(avgv[2:0]) : 0;
    n = 1 << lg;
    sum = 0;
    // R11 burst 0x42..0x47 with start last
    wr(sel, 8'h42, 8'($urandom));
    wr(sel, 8'h43, avgv);
    wr(sel, 8'h44, chan);
    wr(sel, 8'h45, 8'(idx));
    wr(sel, 8'h46, 8'h80);
    wr(sel, 8'h47, 8'h80);
    peek(sel, 8'h08, v); chk("R3 status1 after start", v, 8'h02);
    peek(sel, 8'h09, v); chk("R3 status2 settle", v, 8'h10);
    chk("R3 mux_sel", sel ? mux_b : mux_a, chan);
    svalid = 1'b1; sdata = 16'hFFFF;
    cnt = 0; seen = 0;
    while (!seen) begin
      @(posedge clk); cnt++; #1;
      seen = sel ? sen_b : sen_a;
    end
    svalid = 1'b0;
    chk(sel ? "R5 settle edges old table" : "R4 settle edges", cnt,
        settle_ref(idx, !sel) * TPU + 1);
    peek(sel, 8'h09, v); chk("R6 status2 sample", v, 8'h20);
    for (int i = 0; i < n; i++) begin
      if (i == 0 && busy_req) begin
        addr = 8'h47; wdata = 8'h80;
        if (sel) we_b = 1'b1; else we_a = 1'b1;
        @(posedge clk); #1; we_a = 1'b0; we_b = 1'b0;
        peek(sel, 8'h09, v); chk("R10 start while busy ignored", v, 8'h20);
      end
      repeat ($urandom_range(0, 2)) @(posedge clk);
      #1;
      svalid = 1'b1;
      sdata = ones ? 16'hFFFF : 16'($urandom);
      sum += int'(sdata);
      @(posedge clk); #1;
      svalid = 1'b0;
    end
    peek(sel, 8'h09, v); chk("R8 status2 average", v, 8'h30);
    exp_res = (sum >> lg) & 16'hFFFF;
    @(posedge clk); #1;
    chk("R8 irq high", sel ? irq_b : irq_a, 1);
    peek(sel, 8'h08, v); chk("R8 status1 done", v, 8'h01);
    peek(sel, 8'h09, v); chk("R8 status2 done", v, 8'h40);
    peek(sel, 8'h50, v); chk("R7 result low", v, exp_res & 8'hFF);
    peek(sel, 8'h51, v); chk("R7 result high", v, exp_res >> 8);
    @(posedge clk); #1;
    chk("R8 irq single cycle", sel ? irq_b : irq_a, 0);
    peek(sel, 8'h09, v); chk("R8 back to idle", v, 8'h00);
  endtask

  initial begin
    logic [7:0] v, d;
    bit any;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R2 reset state
    peek(0, 8'h08, v); chk("R2 status1", v, 0);
    peek(0, 8'h09, v); chk("R2 status2", v, 0);
    for (int a = 8'h42; a <= 8'h46; a++) begin
      peek(0, 8'(a), v); chk("R2 config zero", v, 0);
    end
    chk("R2 irq low", irq_a, 0);
    chk("R2 sample_en low", sen_a, 0);
    // R1 revision and masks
    peek(0, 8'h00, v); chk("R1 minor rev", v, 3);
    peek(0, 8'h01, v); chk("R1 major rev", v, 5);
    peek(1, 8'h00, v); chk("R1 old minor rev", v, 2);
    for (int k = 0; k < 3; k++) begin
      d = 8'($urandom); wr(0, 8'h42, d); peek(0, 8'h42, v); chk("R1 dig param mask", v, d & 8'h7C);
      d = 8'($urandom); wr(0, 8'h43, d); peek(0, 8'h43, v); chk("R1 avg mask", v, d & 8'h87);
      d = 8'($urandom); wr(0, 8'h44, d); peek(0, 8'h44, v); chk("R1 channel", v, d);
      d = 8'($urandom); wr(0, 8'h45, d); peek(0, 8'h45, v); chk("R1 settle mask", v, d & 8'h0F);
      d = 8'($urandom); wr(0, 8'h46, d & 8'h7F); peek(0, 8'h46, v); chk("R1 enable mask", v, 0);
    end
    wr(0, 8'h47, 8'h00); peek(0, 8'h47, v); chk("R1 start reads zero", v, 0);
    // directed conversions
    run_conv(0, 0, 8'h03, 8'h11, 0, 0);   // R7 averaging disabled -> one sample
    run_conv(0, 1, 8'h82, 8'h05, 0, 1);   // R10 busy request, 4 samples
    // R9 start while disabled
    wr(0, 8'h46, 8'h00);
    wr(0, 8'h47, 8'h80);
    peek(0, 8'h08, v); chk("R9 status1 unchanged", v, 8'h01);
    peek(0, 8'h09, v); chk("R9 stays idle", v, 8'h00);
    any = 0;
    repeat (40) begin @(posedge clk); #1; if (sen_a) any = 1; end
    chk("R9 no sampling", any, 0);
    run_conv(1, 8, 8'h81, 8'h22, 0, 0);   // R5 800 us
    run_conv(1, 10, 8'h80, 8'h23, 0, 0);  // R5 1 ms
    run_conv(0, 8, 8'h80, 8'h24, 0, 0);   // R4 1 ms
    run_conv(0, 9, 8'h81, 8'h25, 0, 0);   // R4 2 ms
    run_conv(0, 2, 8'h87, 8'h26, 1, 0);   // R7 128 samples all ones
    for (int r = 0; r < 8; r++) begin
      run_conv(r[0], $urandom_range(0, 9),
               {1'($urandom), 4'd0, 3'($urandom_range(0, 5))},
               8'($urandom), 0, r[1]);
    end
    summary();
  end
endmodule